// File: doc/BRIEF.md
# Fully Associative Tag Match Unit

This block holds the tags of a fully associative cache. Each of its entries stores a valid flag and a tag. On every cycle the lookup tag is compared against all entries at once. The unit reports a hit flag and the binary position of the entry that matched. Both outputs are combinational and depend only on the registered entry state.

Three update operations act on the store:

- An allocation writes a tag into an empty entry. It can instead write into an entry the caller names.
- An invalidation drops an entry.
- The unit always exposes whether any entry is empty and which empty entry has the lowest number, so the surrounding logic can steer allocations.

Choosing a victim, holding line data and talking to memory are jobs for the logic around this block.

Top module: `assoc_tag_cam`

## Requirements
- R1: After reset every entry is empty. With no allocation made, the outputs read hit=0, freeAny=1 and freeIdx=0 for any lookup tag.
- R2: hit is 1 in the same cycle exactly when some valid entry stores a tag equal to lookupTag. Otherwise it is 0.
- R3: On a hit, hitIdx gives the number of the matching entry as an unsigned binary value, with entry 0 first. Stored tags are assumed unique.
- R4: An entry whose valid flag is clear never produces a hit, even when its stored tag equals lookupTag.
- R5: freeAny is 1 exactly when at least one entry is empty. freeIdx is then the lowest-numbered empty entry. When no entry is empty, freeIdx reads 0.
- R6: allocEn=1 with allocForce=0 while an empty entry exists stores allocTag in the entry given by freeIdx. That entry is valid from the next cycle.
- R7: allocEn=1 with allocForce=0 while no entry is empty overwrites the entry given by allocIdx with allocTag.
- R8: allocEn=1 with allocForce=1 writes allocTag into allocIdx even when empty entries exist. The empty entries remain empty.
- R9: invalEn=1 clears the valid flag of entry invalIdx from the next cycle. All other entries keep their state.
- R10: A lookup in the same cycle as an allocation sees the contents from before that allocation.
- R11: When the entry being allocated and invalidated in the same cycle is the same one, the allocation wins and the entry ends up valid with the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupTag | input | TAG_W | Tag to search for |
| hit | output | 1 | Some valid entry matches lookupTag |
| hitIdx | output | IDX_W | Number of the matching entry |
| allocEn | input | 1 | Allocate allocTag this cycle |
| allocForce | input | 1 | Write into allocIdx instead of an empty entry |
| allocIdx | input | IDX_W | Victim or forced target entry |
| allocTag | input | TAG_W | Tag to store |
| invalEn | input | 1 | Invalidate an entry this cycle |
| invalIdx | input | IDX_W | Entry to invalidate |
| freeAny | output | 1 | At least one entry is empty |
| freeIdx | output | IDX_W | Lowest-numbered empty entry |

## Verification
After each state change, the bench probes the tag of every entry, one entry at a time. Valid entries must hit at their own position. Invalidated entries and replaced tags must miss, which separates a stale valid flag from a broken comparator. A tag that was never written is also probed, to confirm that hit falls low when nothing matches. The store is exercised while filling in order, when full with the victim path, with holes opened at non-adjacent positions so that freeIdx must choose the lower one, with a forced write alongside free slots, with a same-entry allocate and invalidate, and while draining completely. The lookup is also driven with the tag being allocated during the allocating cycle, to show that the write is not yet visible.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;

  // where an allocation lands
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FREE   = 2'd1,
    SRC_VICTIM = 2'd2,
    SRC_FORCED = 2'd3
  } allocSrc_e;

  // strobes from control to the entry store
  typedef struct packed {
    logic      wrEn;
    logic      clrEn;
    allocSrc_e src;
  } camStrobes_t;

endpackage

// File: rtl/tag_cam_store.sv
module tag_cam_store
  import tag_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int TAG_W       = 26,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  camStrobes_t            stb,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [TAG_W-1:0]       wrTag,
  input  logic [IDX_W-1:0]       clrIdx,
  input  logic [TAG_W-1:0]       lookupTag,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx
);

  logic [NUM_ENTRIES-1:0] matchVec;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [TAG_W-1:0] tagQ;
    logic             validQ;
    logic             selWr;
    logic             selClr;

    assign selWr  = stb.wrEn  && (wrIdx  == IDX_W'(e));
    assign selClr = stb.clrEn && (clrIdx == IDX_W'(e));

    // valid flag: a write in the same cycle overrides a clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       validQ <= 1'b0;
      else if (selWr)  validQ <= 1'b1;
      else if (selClr) validQ <= 1'b0;
    end

    // tag storage carries no reset; the valid flag guards it
    always_ff @(posedge clk) begin
      if (selWr) tagQ <= wrTag;
    end

    assign validVec[e] = validQ;
    assign matchVec[e] = validQ && (tagQ == lookupTag);
  end

  // OR reduction for the hit flag
  assign hit = |matchVec;

  // one-hot to binary: OR together the numbers of the set bits
  always_comb begin
    hitIdx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (matchVec[e]) hitIdx = hitIdx | IDX_W'(e);
    end
  end

endmodule

// File: rtl/tag_cam_ctrl.sv
module tag_cam_ctrl
  import tag_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic                   allocEn,
  input  logic                   allocForce,
  input  logic [IDX_W-1:0]       allocIdx,
  input  logic                   invalEn,
  input  logic [IDX_W-1:0]       invalIdx,
  output camStrobes_t            stb,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-1:0]       clrIdx,
  output logic                   freeAny,
  output logic [IDX_W-1:0]       freeIdx
);

  logic [NUM_ENTRIES-1:0] emptyVec;

  assign emptyVec = ~validVec;
  assign freeAny  = |emptyVec;

  // lowest empty entry: scan downward so the smallest number is kept last
  always_comb begin
    freeIdx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (emptyVec[e]) freeIdx = IDX_W'(e);
    end
  end

  // choose where the allocation goes
  always_comb begin
    if (!allocEn)        stb.src = SRC_NONE;
    else if (allocForce) stb.src = SRC_FORCED;
    else if (freeAny)    stb.src = SRC_FREE;
    else                 stb.src = SRC_VICTIM;
  end

  assign stb.wrEn  = allocEn;
  assign stb.clrEn = invalEn;
  assign wrIdx     = (stb.src == SRC_FREE) ? freeIdx : allocIdx;
  assign clrIdx    = invalIdx;

endmodule

// File: rtl/assoc_tag_cam.sv
module assoc_tag_cam
  import tag_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int TAG_W       = 26,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] lookupTag,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  input  logic             allocEn,
  input  logic             allocForce,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic [TAG_W-1:0] allocTag,
  input  logic             invalEn,
  input  logic [IDX_W-1:0] invalIdx,
  output logic             freeAny,
  output logic [IDX_W-1:0] freeIdx
);

  camStrobes_t            stb;
  logic [IDX_W-1:0]       wrIdx;
  logic [IDX_W-1:0]       clrIdx;
  logic [NUM_ENTRIES-1:0] entryValid;

  tag_cam_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) ctrl_i (
    .validVec  (entryValid),
    .allocEn   (allocEn),
    .allocForce(allocForce),
    .allocIdx  (allocIdx),
    .invalEn   (invalEn),
    .invalIdx  (invalIdx),
    .stb       (stb),
    .wrIdx     (wrIdx),
    .clrIdx    (clrIdx),
    .freeAny   (freeAny),
    .freeIdx   (freeIdx)
  );

  tag_cam_store #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .TAG_W      (TAG_W),
    .IDX_W      (IDX_W)
  ) store_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrIdx    (wrIdx),
    .wrTag    (allocTag),
    .clrIdx   (clrIdx),
    .lookupTag(lookupTag),
    .validVec (entryValid),
    .hit      (hit),
    .hitIdx   (hitIdx)
  );

endmodule

// File: rtl/tag_cam_checker.sv
module tag_cam_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   allocEn,
  input logic                   allocForce,
  input logic [IDX_W-1:0]       allocIdx,
  input logic                   invalEn,
  input logic [IDX_W-1:0]       invalIdx,
  input logic                   hit,
  input logic [IDX_W-1:0]       hitIdx,
  input logic                   freeAny,
  input logic [IDX_W-1:0]       freeIdx,
  input logic [NUM_ENTRIES-1:0] entryValid
);

  // R4: a reported hit always points at a valid entry
  assert_hit_on_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> entryValid[hitIdx]);

  // R5: the reported empty entry really is empty
  assert_free_is_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    freeAny |-> !entryValid[freeIdx]);

  // R5: freeAny falls only when every entry is valid
  assert_full_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    !freeAny |-> (&entryValid));

  // R6: an allocation into an empty entry makes it valid
  assert_alloc_free_R6: assert property (@(posedge clk) disable iff (!rstN)
    (allocEn && !allocForce && freeAny) |=> entryValid[$past(freeIdx)]);

  // R8: a forced allocation makes the named entry valid
  assert_alloc_forced_R8: assert property (@(posedge clk) disable iff (!rstN)
    (allocEn && allocForce) |=> entryValid[$past(allocIdx)]);

  // R9: an invalidation without a competing allocation empties the entry
  assert_inval_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (invalEn && !allocEn) |=> !entryValid[$past(invalIdx)]);

  // R9: with no update requested, the valid flags hold
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!invalEn && !allocEn) |=> $stable(entryValid));

  // R5: no valid entry sits below freeIdx when a free entry exists
  always @(posedge clk) begin
    if (rstN && freeAny) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (IDX_W'(e) < freeIdx)
          assert_free_lowest_R5: assert (entryValid[e]);
      end
    end
  end

endmodule

bind assoc_tag_cam tag_cam_checker #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .IDX_W      (IDX_W)
) checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .allocEn   (allocEn),
  .allocForce(allocForce),
  .allocIdx  (allocIdx),
  .invalEn   (invalEn),
  .invalIdx  (invalIdx),
  .hit       (hit),
  .hitIdx    (hitIdx),
  .freeAny   (freeAny),
  .freeIdx   (freeIdx),
  .entryValid(entryValid)
);

// File: tb/assoc_tag_cam_tb.sv
module assoc_tag_cam_tb_top;

  localparam int N  = 8;
  localparam int TW = 26;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] lookupTag = '0;
  logic          hit;
  logic [IW-1:0] hitIdx;
  logic          allocEn = 1'b0;
  logic          allocForce = 1'b0;
  logic [IW-1:0] allocIdx = '0;
  logic [TW-1:0] allocTag = '0;
  logic          invalEn = 1'b0;
  logic [IW-1:0] invalIdx = '0;
  logic          freeAny;
  logic [IW-1:0] freeIdx;

  int total = 0;
  int bad   = 0;

  // bench-side model of the store
  bit            mValid [N];
  logic [TW-1:0] mTag   [N];

  always #4 clk = ~clk;

  assoc_tag_cam #(.NUM_ENTRIES(N), .TAG_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .lookupTag(lookupTag), .hit(hit), .hitIdx(hitIdx),
    .allocEn(allocEn), .allocForce(allocForce), .allocIdx(allocIdx),
    .allocTag(allocTag), .invalEn(invalEn), .invalIdx(invalIdx),
    .freeAny(freeAny), .freeIdx(freeIdx)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowestFree();
    for (int e = 0; e < N; e++) if (!mValid[e]) return e;
    return -1;
  endfunction

  // checks hit and index for one probe tag against the model
  task automatic probe(input logic [TW-1:0] t, input string req);
    int expIdx = -1;
    for (int e = 0; e < N; e++) if (mValid[e] && mTag[e] == t) expIdx = e;
    lookupTag = t;
    #1;
    chk({req, " hit"}, int'(hit), (expIdx >= 0) ? 1 : 0);
    if (expIdx >= 0) chk({req, " R3 idx"}, int'(hitIdx), expIdx);
  endtask

  // full sweep across every stored tag plus a tag never written
  task automatic sweep(input string req);
    int lf;
    @(negedge clk);
    allocEn = 0; allocForce = 0; invalEn = 0;
    for (int e = 0; e < N; e++) probe(mTag[e], req);
    probe(26'h2aaaaaa, {req, " R2 absent"});
    lf = lowestFree();
    chk({req, " R5 freeAny"}, int'(freeAny), (lf >= 0) ? 1 : 0);
    chk({req, " R5 freeIdx"}, int'(freeIdx), (lf >= 0) ? lf : 0);
  endtask

  // one update cycle; lookup probes the new tag during it (R10)
  task automatic op(input bit aEn, input bit aForce, input int aIdx,
                    input logic [TW-1:0] aTag, input bit iEn, input int iIdx);
    int target;
    int lf;
    @(negedge clk);
    allocEn = aEn; allocForce = aForce; allocIdx = IW'(aIdx); allocTag = aTag;
    invalEn = iEn; invalIdx = IW'(iIdx);
    if (aEn) probe(aTag, "R10 pre-write");
    lf = lowestFree();
    target = aForce ? aIdx : ((lf >= 0) ? lf : aIdx);
    @(posedge clk);
    if (iEn) mValid[iIdx] = 0;
    if (aEn) begin
      mValid[target] = 1;
      mTag[target]   = aTag;
    end
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin
      mValid[e] = 0;
      mTag[e]   = TW'(26'h3ff0000 + e);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    lookupTag = '0; #1;
    chk("R1 hit zero tag", int'(hit), 0);
    chk("R1 freeAny", int'(freeAny), 1);
    chk("R1 freeIdx", int'(freeIdx), 0);
    rstN = 1'b1;
    sweep("R1 after reset");

    // R6: fill in order, free slot chosen each time
    for (int k = 0; k < N; k++) begin
      op(1, 0, 7 - k, TW'(26'h0100000 + k * 26'h13579), 0, 0);
      sweep("R6 fill R2");
    end

    // R7: full store, victim path
    op(1, 0, 5, 26'h1234567, 0, 0);
    sweep("R7 victim");

    // R9, R4: open holes at 6 and 2, freeIdx must pick 2
    op(0, 0, 0, '0, 1, 6);
    sweep("R9 inval6 R4");
    op(0, 0, 0, '0, 1, 2);
    sweep("R9 inval2 R5");

    // R8: forced write while holes exist
    op(1, 1, 7, 26'h0abcdef, 0, 0);
    sweep("R8 forced");

    // R11: same-entry allocate and invalidate
    op(1, 1, 0, 26'h0fedcba, 1, 0);
    sweep("R11 same entry");

    // R6 with simultaneous invalidate elsewhere
    op(1, 0, 0, 26'h0333333, 1, 4);
    sweep("R6 alloc plus R9 inval");

    // drain everything
    for (int k = 0; k < N; k++) begin
      op(0, 0, 0, '0, 1, k);
      sweep("R9 drain R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule